// File: doc/BRIEF.md
# Overwriting One-Entry Signal Mailbox

The block carries single messages from one hardware process to another. A producer posts a value by raising a post enable with the value on the post data input. There is no ready line on that side, so a post is never refused and never stalls. The message is kept in a holding register, and a pending flag records that it has not been consumed yet.

On the consumer side, a ready output shows that a message is waiting. The consumer takes the message by sampling the data output and raising the read enable while ready is high. If a new post arrives before the earlier message has been read, the newer value replaces the older one and ready stays high. No count of lost messages is kept.

The data width is a parameter. The block has no end-of-stream line and works in a single clock domain.

Top module: `sig_mailbox`

## Requirements
- R1: While reset is asserted and after its release, before any post, wait_rdy_o is 0 and wait_data_o is all zeros.
- R2: A cycle with post_en_i high stores post_data_i. From the next clock edge, wait_rdy_o is 1 and wait_data_o equals the posted value.
- R3: A post while a message is pending replaces the stored value with the new one, and wait_rdy_o stays 1.
- R4: A cycle with wait_en_i high, wait_rdy_o high and post_en_i low clears wait_rdy_o at the next clock edge.
- R5: In a cycle where post and read happen together, wait_data_o shows the older value during that cycle. After the edge, the new value is pending and wait_rdy_o stays 1.
- R6: wait_en_i while wait_rdy_o is 0 has no effect: wait_rdy_o stays 0 and wait_data_o does not change.
- R7: Without a post, wait_data_o keeps its value, including after the message has been consumed.
- R8: A pending message stays pending, with wait_rdy_o at 1, for as many cycles as no read happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| post_en_i | input | 1 | Post the value on post_data_i this cycle |
| post_data_i | input | DATA_W | Value to post |
| wait_rdy_o | output | 1 | A message is pending |
| wait_en_i | input | 1 | Consume the pending message |
| wait_data_o | output | DATA_W | Stored message |

## Verification
The flag and the holding register are both visible at the ports, so a wrong pending state shows on wait_rdy_o one edge after the post or read that caused it. Two errors need specific stimulus to show up. A bad overwrite shows only when the bench posts back to back. A lost collision value shows only when post and read land in the same cycle. The bench covers both cases, and it also holds messages across idle stretches so that a flag that decays on its own is caught.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef enum logic [1:0] {
    MBX_IDLE    = 2'b00,
    MBX_POST    = 2'b01,
    MBX_TAKE    = 2'b10,
    MBX_POST_TK = 2'b11
  } mbx_op_e;
endpackage

// File: rtl/mbx_hold_reg.sv
module mbx_hold_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] q_o
);
  logic [DATA_W-1:0] q_r;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_r <= '0;
    else if (load_i) q_r <= d_i;
  end

  assign q_o = q_r;

  p_capture_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (q_o == $past(d_i)));
  p_hold_stable_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(q_o));
endmodule

// File: rtl/mbx_pend_ctrl.sv
module mbx_pend_ctrl
  import mbx_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic post_i,
  input  logic take_i,
  output logic pend_o
);
  logic    pend_r;
  mbx_op_e op;

  assign op = mbx_op_e'({take_i, post_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_r <= 1'b0;
    else begin
      unique case (op)
        MBX_POST, MBX_POST_TK: pend_r <= 1'b1; // newer post wins over read
        MBX_TAKE:              pend_r <= 1'b0;
        default:               pend_r <= pend_r;
      endcase
    end
  end

  assign pend_o = pend_r;

  p_post_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    post_i |=> pend_o);
  p_read_clears_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && !post_i) |=> !pend_o);
  p_idle_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!take_i && !post_i) |=> $stable(pend_o));
endmodule

// File: rtl/sig_mailbox.sv
module sig_mailbox #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              post_en_i,
  input  logic [DATA_W-1:0] post_data_i,
  output logic              wait_rdy_o,
  input  logic              wait_en_i,
  output logic [DATA_W-1:0] wait_data_o
);
  logic pend;
  logic take;

  // a read only counts while a message is pending
  assign take = wait_en_i & pend;

  mbx_pend_ctrl u_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .post_i (post_en_i),
    .take_i (take),
    .pend_o (pend)
  );

  mbx_hold_reg #(.DATA_W(DATA_W)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (post_en_i),
    .d_i    (post_data_i),
    .q_o    (wait_data_o)
  );

  assign wait_rdy_o = pend;

  p_no_effect_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wait_rdy_o && !post_en_i) |=> (!wait_rdy_o && $stable(wait_data_o)));
  p_collide_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (post_en_i && wait_en_i && wait_rdy_o) |=> (wait_rdy_o && wait_data_o == $past(post_data_i)));
  p_reset_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (!wait_rdy_o && wait_data_o == '0));
endmodule

// File: tb/sig_mailbox_bench.sv
module sig_mailbox_bench;
  localparam int DATA_W = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              post_en = 1'b0;
  logic [DATA_W-1:0] post_data = '0;
  logic              rdy;
  logic              rd_en = 1'b0;
  logic [DATA_W-1:0] rd_data;

  int tests = 0;
  int fails = 0;
  logic              m_pend = 1'b0;
  logic [DATA_W-1:0] m_data = '0;

  typedef struct {
    logic              rdy;
    logic [DATA_W-1:0] data;
    string             req;
  } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;

  sig_mailbox #(.DATA_W(DATA_W)) u_sig_mailbox (
    .clk_i(clk), .rst_ni(rst_n),
    .post_en_i(post_en), .post_data_i(post_data),
    .wait_rdy_o(rdy), .wait_en_i(rd_en), .wait_data_o(rd_data)
  );

  task automatic check(string req, logic r, logic [DATA_W-1:0] d,
                       logic er, logic [DATA_W-1:0] ed);
    tests++;
    if (r !== er || d !== ed) begin
      fails++;
      $display("FAIL %s: rdy=%0b data=%h expected rdy=%0b data=%h", req, r, d, er, ed);
    end
  endtask

  // one cycle of stimulus; model predicts state after the edge
  task automatic cyc(string req, logic p, logic [DATA_W-1:0] pd, logic r);
    exp_t e;
    @(negedge clk);
    post_en = p; post_data = pd; rd_en = r;
    #1;
    if (r && p && m_pend) check("R5 old value during collision", rdy, rd_data, m_pend, m_data);
    if (p) begin m_data = pd; m_pend = 1'b1; end
    else if (r && m_pend) m_pend = 1'b0;
    e.rdy = m_pend; e.data = m_data; e.req = req;
    q.push_back(e);
  endtask

  // monitor
  always @(posedge clk) begin
    #5;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(e.req, rdy, rd_data, e.rdy, e.data);
    end
  end

  initial begin
    #(20 * 200000);
    fails++; tests++;
    $display("FAIL watchdog: rdy=%0b data=%h expected finish", rdy, rd_data);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #5;
    check("R1 in reset", rdy, rd_data, 1'b0, '0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check("R1 after release", rdy, rd_data, 1'b0, '0);
    cyc("R6 read while empty", 1'b0, 16'hdead, 1'b1);
    cyc("R2 post", 1'b1, 16'h1234, 1'b0);
    cyc("R8 hold", 1'b0, 16'h0, 1'b0);
    cyc("R8 hold", 1'b0, 16'hffff, 1'b0);
    cyc("R3 overwrite", 1'b1, 16'habcd, 1'b0);
    cyc("R3 overwrite again", 1'b1, 16'h0f0f, 1'b0);
    cyc("R4 read clears", 1'b0, 16'h0, 1'b1);
    cyc("R7 data kept", 1'b0, 16'h5555, 1'b0);
    cyc("R6 read while empty", 1'b0, 16'h7777, 1'b1);
    cyc("R2 post", 1'b1, 16'h8001, 1'b0);
    cyc("R5 collision", 1'b1, 16'h4242, 1'b1);
    cyc("R4 read after collision", 1'b0, 16'h0, 1'b1);
    cyc("R5 post with read while empty", 1'b1, 16'hbeef, 1'b1);
    cyc("R4 read clears", 1'b0, 16'h0, 1'b1);
    for (int i = 0; i < 20; i++)
      cyc("R2 pattern", i[0], 16'(i * 16'h1357), i[1]);
    cyc("R7 idle", 1'b0, 16'h0, 1'b0);
    @(negedge clk); @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule